// File: doc/BRIEF.md
# Clock Gear Divider with Deferred Ratio Switching

This block turns a fast input clock into a slower system rate. The input rate is divided by 1, 2, 4, 8 or 16. There are no gated clocks. The system clock appears as a one-cycle enable strobe, `sys_ce`, and downstream logic qualifies its flops with it. Software reaches the block through a write-only port made of a strobe, an address and a data byte. One register holds the oscillator enables and the source select. A second register holds the 3-bit gear code.

A gear write does not take effect at once. The written code is held as pending, and a settling counter is loaded. The new ratio is applied only after the counter has run out and the current divided period has ended. Because of this, every strobe interval is a whole period of either the old ratio or the new one. A busy flag is high for the whole pending window. After reset the block runs at the slowest gear, with the high-speed oscillator enabled and the high-speed path selected.

Top module: `cgear_top`

## Requirements
- R1: Gear codes 0, 1, 2, 3 and 4 give a strobe every 1, 2, 4, 8 and 16 input cycles, one cycle wide.
- R2: During and after reset, `gear_now` = 4 (/16), `gear_busy` = 0, `hs_osc_en` = 1, `ls_osc_en` = 0 and `src_sel` = 0. Strobes then come every 16 cycles.
- R3: A write to address 0 loads `hs_osc_en` from data bit 0, `ls_osc_en` from bit 1 and `src_sel` from bit 2. A write to address 1 loads the gear code from data bits 2:0, and bits 7:3 are ignored. Writes to addresses 2 and 3 change nothing.
- R4: Codes 5, 6 and 7 are reported unchanged on `gear_now` and divide by 16.
- R5: `gear_busy` is high on the cycle after a gear write and stays high for at least SETTLE+1 cycles. While busy, `gear_now` and the strobe ratio keep their old values.
- R6: The ratio changes only at the end of a period. Every strobe interval during a change equals the old period or the new one.
- R7: `gear_busy` drops on the cycle the new ratio becomes active. With the divider running, the busy window is at most SETTLE plus the old period, in cycles.
- R8: A gear write while a change is pending replaces the pending code and restarts the settling interval. The last code written is the one applied.
- R9: No strobe is produced while `hs_osc_en` = 0 or `src_sel` = 1. While stopped, a gear change applies exactly SETTLE+1 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 gear) |
| wr_data | input | 8 | Write data |
| sys_ce | output | 1 | One-cycle system clock enable strobe |
| gear_busy | output | 1 | Gear change pending |
| gear_now | output | 3 | Gear code currently in force |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| src_sel | output | 1 | Clock source select (0 = divided high-speed path) |

## Verification
The hardest cases to reach from the ports are the ones where a change overlaps another event. One is a gear change whose settling window ends part-way through a long old period. Another is a second write that lands while the first is still pending.

The bench runs a change from each gear to the next, so the old period is sometimes long and sometimes short. It measures every strobe interval and every busy window. It also issues back-to-back gear writes two cycles apart. Finally, it stops the divider through the control register and writes a gear while stopped, where the apply cycle is exact.

// File: rtl/cgear_pkg.sv
package cgear_pkg;
  localparam int GEAR_W    = 3;
  localparam int MAX_SHIFT = 4;
  localparam int CNT_W     = MAX_SHIFT;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_GEAR = 2'd1;

  typedef logic [GEAR_W-1:0] gear_t;

  localparam gear_t GEAR_RESET = gear_t'(MAX_SHIFT);

  // Number of halvings for a gear code; reserved codes fall back to the slowest.
  function automatic logic [2:0] gear_shift(gear_t g);
    return (g > gear_t'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : 3'(g);
  endfunction

  // Final counter value of one divided period.
  function automatic logic [CNT_W-1:0] period_last(gear_t g);
    logic [CNT_W:0] one;
    logic [CNT_W:0] full;
    one  = 1;
    full = one << gear_shift(g);
    return CNT_W'(full - 1'b1);
  endfunction
endpackage

// File: rtl/cgear_regs.sv
module cgear_regs
  import cgear_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hs_en,
  output logic              ls_en,
  output logic              src_sel,
  output logic              gear_wr,
  output gear_t             gear_wdata
);
  logic ctrl_wr;
  logic unused_hi;

  assign ctrl_wr    = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign gear_wr    = wr_en && (wr_addr == ADDR_W'(ADDR_GEAR));
  assign gear_wdata = wr_data[GEAR_W-1:0];
  assign unused_hi  = ^wr_data[DATA_W-1:GEAR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_en   <= 1'b1;
      ls_en   <= 1'b0;
      src_sel <= 1'b0;
    end else if (ctrl_wr) begin
      hs_en   <= wr_data[0];
      ls_en   <= wr_data[1];
      src_sel <= wr_data[2];
    end
  end
endmodule

// File: rtl/cgear_switch.sv
module cgear_switch
  import cgear_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  gear_wr,
  input  gear_t gear_wdata,
  input  logic  period_end,
  input  logic  run,
  output gear_t gear_now,
  output logic  busy,
  output logic  apply_now
);
  localparam int SET_W = $clog2(SETTLE + 1);

  gear_t            pend;
  logic [SET_W-1:0] settle;
  logic             settle_done;

  assign settle_done = (settle == '0);
  assign apply_now   = busy && settle_done && !gear_wr && (period_end || !run);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gear_now <= GEAR_RESET;
      pend     <= GEAR_RESET;
      busy     <= 1'b0;
      settle   <= '0;
    end else if (gear_wr) begin
      pend   <= gear_wdata;
      busy   <= 1'b1;
      settle <= SET_W'(SETTLE);
    end else begin
      if (!settle_done) settle <= settle - 1'b1;
      if (apply_now) begin
        gear_now <= pend;
        busy     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cgear_div.sv
module cgear_div
  import cgear_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  gear_t gear_now,
  output logic  period_end
);
  logic [CNT_W-1:0] cnt;

  assign period_end = run && (cnt == period_last(gear_now));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (period_end)      cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cgear_top.sv
module cgear_top
  import cgear_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sys_ce,
  output logic              gear_busy,
  output logic [2:0]        gear_now,
  output logic              hs_osc_en,
  output logic              ls_osc_en,
  output logic              src_sel
);
  logic  gear_wr;
  gear_t gear_wdata;
  logic  run;
  logic  period_end;
  logic  apply_now;
  gear_t cur_gear;

  cgear_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hs_en(hs_osc_en), .ls_en(ls_osc_en), .src_sel(src_sel),
    .gear_wr(gear_wr), .gear_wdata(gear_wdata)
  );

  assign run = hs_osc_en && !src_sel;

  cgear_switch #(.SETTLE(SETTLE)) u_switch (
    .clk(clk), .rst_n(rst_n), .gear_wr(gear_wr), .gear_wdata(gear_wdata),
    .period_end(period_end), .run(run),
    .gear_now(cur_gear), .busy(gear_busy), .apply_now(apply_now)
  );

  cgear_div u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .gear_now(cur_gear), .period_end(period_end)
  );

  assign sys_ce   = period_end;
  assign gear_now = cur_gear;
endmodule

// File: rtl/cgear_chk.sv
module cgear_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_ce,
  input logic       gear_busy,
  input logic [2:0] gear_now,
  input logic       hs_osc_en,
  input logic       src_sel,
  input logic       period_end,
  input logic       apply_now,
  input logic       gear_wr,
  input logic       run
);
  // R5: the active gear moves only out of a pending window
  a_r5_gear_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gear_now) |-> $past(gear_busy));

  // R5: a fresh pending window never applies on its first cycle
  a_r5_no_instant_apply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gear_busy) |-> !apply_now);

  // R6: a running divider switches only at a period end
  a_r6_apply_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_now && run) |-> period_end);

  // R7: applying clears busy
  a_r7_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    apply_now |=> !gear_busy);

  // R8: any gear write arms the pending window
  a_r8_write_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    gear_wr |=> gear_busy);

  // R9: silent while the oscillator is off or the other source is chosen
  a_r9_silent_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_osc_en || src_sel) |-> !sys_ce);
endmodule

bind cgear_top cgear_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .gear_busy(gear_busy),
  .gear_now(gear_now), .hs_osc_en(hs_osc_en), .src_sel(src_sel),
  .period_end(period_end), .apply_now(apply_now), .gear_wr(gear_wr), .run(run)
);

// File: tb/sim_cgear_top.sv
module sim_cgear_top;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sys_ce, gear_busy, hs_osc_en, ls_osc_en, src_sel;
  logic [2:0] gear_now;

  cgear_top #(.ADDR_W(2), .DATA_W(8), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_ce(sys_ce), .gear_busy(gear_busy), .gear_now(gear_now),
    .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en), .src_sel(src_sel)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  int alt_a = 0, alt_b = 0;
  bit lenient = 0;
  bit resync = 0;
  bit have_last = 0;
  int gap = 0;
  int exp_len = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures strobe intervals and compares them with the scoreboard queue
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0;
      have_last = 0;
    end else begin
      gap++;
      if (sys_ce) begin
        if (have_last && !resync) begin
          if (exp_q.size() > 0) begin
            exp_len = exp_q.pop_front();
            check(gap == exp_len, "R1 strobe period", gap, exp_len);
          end else if (lenient) begin
            check(gap == alt_a || gap == alt_b, "R6 interval old-or-new", gap, alt_b);
          end
        end
        gap = 0;
        have_last = 1;
        resync = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_run(int len, int n);
    repeat (n) exp_q.push_back(len);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  // Driver: gear change on a running divider
  task automatic change_gear(logic [7:0] d, int old_len, int new_len, int exp_gear, string req);
    int busy_n;
    int g0;
    bit held;
    g0 = gear_now; held = 1; busy_n = 0;
    alt_a = old_len; alt_b = new_len; lenient = 1;
    wr(2'd1, d);
    check(gear_busy == 1'b1, "R5 busy after write", gear_busy, 1);
    while (gear_busy) begin
      busy_n++;
      if (gear_now != g0) held = 0;
      @(negedge clk);
    end
    check(held, "R5 old gear held while busy", held, 1);
    check(busy_n >= SETTLE + 1, "R5 busy minimum", busy_n, SETTLE + 1);
    check(busy_n <= SETTLE + old_len, "R7 busy maximum", busy_n, SETTLE + old_len);
    check(gear_now == exp_gear, req, gear_now, exp_gear);
    lenient = 0;
    expect_run(new_len, 3);
  endtask

  task automatic count_strobes(int cycles, string req);
    int c;
    c = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (sys_ce) c++;
    end
    check(c == 0, req, c, 0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int busy_n;
    repeat (3) @(negedge clk);
    // R2 reset values
    check(gear_now == 3'd4, "R2 reset gear", gear_now, 4);
    check(gear_busy == 1'b0, "R2 reset busy", gear_busy, 0);
    check(hs_osc_en == 1'b1, "R2 reset hs enable", hs_osc_en, 1);
    check(ls_osc_en == 1'b0, "R2 reset ls enable", ls_osc_en, 0);
    check(src_sel == 1'b0, "R2 reset source", src_sel, 0);
    rst_n = 1'b1;
    expect_run(16, 3);                                   // R2 /16 after reset

    change_gear(8'h01, 16, 2, 1, "R1 gear 1");
    change_gear(8'h02, 2, 4, 2, "R1 gear 2");
    change_gear(8'h03, 4, 8, 3, "R1 gear 3");
    change_gear(8'h00, 8, 1, 0, "R1 gear 0");
    change_gear(8'hF9, 1, 2, 1, "R3 upper gear bits ignored");
    change_gear(8'h06, 2, 16, 6, "R4 reserved code 6");
    change_gear(8'h07, 16, 16, 7, "R4 reserved code 7");
    change_gear(8'h04, 16, 16, 4, "R1 gear 4");

    // R3: unmapped addresses change nothing
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    check(hs_osc_en == 1'b1, "R3 addr 2/3 ignored hs", hs_osc_en, 1);
    check(src_sel == 1'b0, "R3 addr 2/3 ignored src", src_sel, 0);
    check(gear_busy == 1'b0, "R3 addr 2/3 ignored busy", gear_busy, 0);
    check(gear_now == 3'd4, "R3 addr 2/3 ignored gear", gear_now, 4);
    expect_run(16, 2);

    // R3: control register fields
    wr(2'd0, 8'h03);
    check(ls_osc_en == 1'b1, "R3 ls enable bit 1", ls_osc_en, 1);
    check(hs_osc_en == 1'b1, "R3 hs enable bit 0", hs_osc_en, 1);
    check(src_sel == 1'b0, "R3 source bit 2", src_sel, 0);

    // R8: second write while pending
    alt_a = 16; alt_b = 8; lenient = 1;
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h03);
    busy_n = 0;
    while (gear_busy) begin busy_n++; @(negedge clk); end
    check(busy_n >= SETTLE + 1, "R8 settle restarted", busy_n, SETTLE + 1);
    check(gear_now == 3'd3, "R8 last code applied", gear_now, 3);
    lenient = 0;
    expect_run(8, 3);

    // R9: oscillator off
    wr(2'd0, 8'h00);
    check(hs_osc_en == 1'b0, "R3 hs enable cleared", hs_osc_en, 0);
    count_strobes(40, "R9 no strobe with oscillator off");
    wr(2'd1, 8'h01);
    busy_n = 0;
    while (gear_busy) begin busy_n++; @(negedge clk); end
    check(busy_n == SETTLE + 1, "R9 stopped apply timing", busy_n, SETTLE + 1);
    check(gear_now == 3'd1, "R9 gear while stopped", gear_now, 1);

    // R9: other source selected
    wr(2'd0, 8'h05);
    check(src_sel == 1'b1, "R3 source bit set", src_sel, 1);
    count_strobes(40, "R9 no strobe with other source");

    wr(2'd0, 8'h01);
    resync = 1;
    expect_run(2, 3);

    done = 1;
    summary();
    $finish;
  end
endmodule